// File: doc/BRIEF.md
# Sequential Shift-Add Floating-Point Multiplier

This block multiplies two single-precision floating-point words. It does not use a multiplier array. It builds the significand product with one conditional add and one right shift per bit of the multiplier significand, so a full product takes 24 loop cycles. The biased exponent sum is formed when the operands are accepted, while the significand loop is still to run. The result sign is the XOR of the two operand signs.

When the loop ends, the 48-bit significand product has its leading one in one of two adjacent positions. A single one-bit normalization step picks the upper 24 bits and adjusts the exponent if needed. The bits below those 24 are dropped without rounding.

A caller presents both operands with a one-cycle start strobe while the block is idle. It then waits for the one-cycle done pulse, and the product is valid from that cycle on. Either operand being zero short-circuits the loop. An exponent outside the normal range flushes the result to a signed zero.

Top module: `fp_mul_serial`

## Requirements
- R1: While reset is held and after it is released, busy and done are low and result is all zeros until the first operation completes.
- R2: Words use sign at bit 31, a biased exponent (bias 127) at bits 30:23 and a fraction at bits 22:0 with a hidden leading one. For operands with nonzero exponent fields, result is the product formed from the upper 24 bits of the 48-bit significand product.
- R3: The result sign bit equals the XOR of the two operand sign bits, including results that are zero.
- R4: When the significand product is 2 or more (bit 47 of the 48-bit product set), the exponent is ea+eb-127+1 and the fraction is product bits 46:24. Otherwise the exponent is ea+eb-127 and the fraction is product bits 45:23.
- R5: The discarded low product bits never change the result; the fraction is truncated, never rounded.
- R6: An operand whose exponent field is 0 counts as zero whatever its fraction bits. The result is a signed zero, and done rises in the cycle after the accepting edge.
- R7: If the final biased exponent is below 1 or above 254, the result is a signed zero.
- R8: For nonzero operands, done rises after the 26th rising edge, counting the edge that accepts start as the first. Busy is high from the cycle after acceptance through the done cycle.
- R9: Done is high for exactly one cycle. Result changes only in the cycle where done is high and holds its value until the next completion.
- R10: A start strobe while busy is high is ignored. The running operation keeps its operands and its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept operands when idle |
| opa | input | 32 | Multiplicand word |
| opb | input | 32 | Multiplier word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product word |

## Verification
The bench goes after the normalization decision. It uses operand pairs whose significand product lands just under and just over 2. A design that picked the wrong half of the product, or skipped the exponent increment, would be off by a factor of two or would shift the fraction by one bit. It walks exponent pairs across both edges of the representable range, where a missed flush would wrap the exponent field into a huge or tiny number. It sends fraction patterns whose dropped bits are all ones, so a design that rounded would show a fraction one larger. Zero operands with stray fraction bits check that the loop is skipped and the sign kept, and a start pulse in the middle of a run would corrupt the product or its timing if it were not ignored.

// File: rtl/fp_mul_serial_pkg.sv
package fp_mul_serial_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_NORM = 2'd2,
        ST_DONE = 2'd3
    } fpms_state_e;

endpackage

// File: rtl/fpms_unpack.sv
module fpms_unpack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1
) (
    input  logic [W-1:0]     word,
    output logic             sign,
    output logic [EXP_W-1:0] expo,
    output logic [SIG_W-1:0] sig,
    output logic             is_zero
);
    // Exponent field of zero marks a zero operand; denormals are not handled.
    always_comb begin
        sign    = word[W-1];
        expo    = word[W-2 -: EXP_W];
        sig     = {1'b1, word[MAN_W-1:0]};
        is_zero = (expo == '0);
    end
endmodule

// File: rtl/fpms_expsum.sv
module fpms_expsum #(
    parameter int EXP_W = 8,
    localparam int SUM_W = EXP_W + 2
) (
    input  logic [EXP_W-1:0]        ea,
    input  logic [EXP_W-1:0]        eb,
    output logic signed [SUM_W-1:0] sum
);
    localparam logic signed [SUM_W-1:0] BIAS = SUM_W'((1 << (EXP_W - 1)) - 1);

    // Two guard bits keep the sum signed and free of wrap for any field pair.
    always_comb begin
        sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS;
    end
endmodule

// File: rtl/fpms_step.sv
module fpms_step #(
    parameter int SIG_W = 24,
    localparam int P_W  = 2 * SIG_W
) (
    input  logic [P_W-1:0]   prod,
    input  logic [SIG_W-1:0] mcand,
    output logic [P_W-1:0]   prod_next
);
    logic [SIG_W:0] upper_sum;

    // Low half holds the unused multiplier bits; bit 0 selects the add.
    always_comb begin
        upper_sum = {1'b0, prod[P_W-1:SIG_W]} + (prod[0] ? {1'b0, mcand} : '0);
        prod_next = {upper_sum, prod[SIG_W-1:1]};
    end
endmodule

// File: rtl/fpms_normpack.sv
module fpms_normpack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1,
    localparam int P_W   = 2 * SIG_W,
    localparam int SUM_W = EXP_W + 2
) (
    input  logic                    sign,
    input  logic signed [SUM_W-1:0] exp_sum,
    input  logic [P_W-1:0]          prod,
    output logic [W-1:0]            word
);
    localparam logic signed [SUM_W-1:0] EXP_MAX = SUM_W'((1 << EXP_W) - 2);

    logic                    hi;
    logic [MAN_W-1:0]        frac;
    logic signed [SUM_W-1:0] expo;

    // Product of two values in [1,2) lies in [1,4): one shift at most.
    always_comb begin
        hi   = prod[P_W-1];
        frac = hi ? prod[P_W-2 -: MAN_W] : prod[P_W-3 -: MAN_W];
        expo = exp_sum + (hi ? SUM_W'(1) : SUM_W'(0));
        if (expo < SUM_W'(1) || expo > EXP_MAX) begin
            word = {sign, {(W-1){1'b0}}};
        end else begin
            word = {sign, expo[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/fp_mul_serial.sv
module fp_mul_serial
    import fp_mul_serial_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1,
    localparam int P_W   = 2 * SIG_W,
    localparam int SUM_W = EXP_W + 2,
    localparam int CNT_W = $clog2(SIG_W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SIG_W - 1);

    typedef struct packed {
        fpms_state_e             st;
        logic [CNT_W-1:0]        cnt;
        logic                    sign;
        logic signed [SUM_W-1:0] exps;
        logic [SIG_W-1:0]        mcand;
        logic [P_W-1:0]          prod;
        logic [W-1:0]            res;
    } regs_t;

    regs_t q, d;

    logic                    sa, sb, za, zb;
    logic [EXP_W-1:0]        ea, eb;
    logic [SIG_W-1:0]        siga, sigb;
    logic signed [SUM_W-1:0] esum;
    logic [P_W-1:0]          prod_step;
    logic [W-1:0]            packed_word;

    fpms_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_a (
        .word(opa), .sign(sa), .expo(ea), .sig(siga), .is_zero(za)
    );

    fpms_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_b (
        .word(opb), .sign(sb), .expo(eb), .sig(sigb), .is_zero(zb)
    );

    fpms_expsum #(.EXP_W(EXP_W)) u_expsum (
        .ea(ea), .eb(eb), .sum(esum)
    );

    fpms_step #(.SIG_W(SIG_W)) u_step (
        .prod(q.prod), .mcand(q.mcand), .prod_next(prod_step)
    );

    fpms_normpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_normpack (
        .sign(q.sign), .exp_sum(q.exps), .prod(q.prod), .word(packed_word)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.sign = sa ^ sb;
                    d.exps = esum;
                    if (za || zb) begin
                        d.res = {sa ^ sb, {(W-1){1'b0}}};
                        d.st  = ST_DONE;
                    end else begin
                        d.mcand = siga;
                        d.prod  = {{SIG_W{1'b0}}, sigb};
                        d.cnt   = '0;
                        d.st    = ST_MUL;
                    end
                end
            end
            ST_MUL: begin
                d.prod = prod_step;
                if (q.cnt == LAST) begin
                    d.st = ST_NORM;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_NORM: begin
                d.res = packed_word;
                d.st  = ST_DONE;
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != ST_IDLE);
    assign done   = (q.st == ST_DONE);
    assign result = q.res;

endmodule

// File: rtl/fp_mul_serial_chk.sv
module fp_mul_serial_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    logic       sgn_q;
    logic [7:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q <= 1'b0;
            lat_q <= '0;
        end else if (start && !busy) begin
            sgn_q <= opa[W-1] ^ opb[W-1];
            lat_q <= 8'd1;
        end else if (busy && !done && lat_q != 8'hFF) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    a_r3_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result[W-1] == sgn_q);

    a_r7_exp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result[W-2 -: EXP_W] != {EXP_W{1'b1}});

    a_r6_clean_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[W-2 -: EXP_W] == '0) |-> result[MAN_W-1:0] == '0);

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 8'd1 || lat_q == 8'(SIG_W + 2)));

    a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind fp_mul_serial fp_mul_serial_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
);

// File: tb/fp_mul_serial_test.sv
module fp_mul_serial_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, done;
    logic [31:0] result;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    logic [31:0] rng = 32'h1234_5679;

    fp_mul_serial uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .result(result)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            total++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference product built from the requirement text.
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic        s;
        int          ea, eb, e;
        logic [47:0] p;
        logic [22:0] m;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        if (ea == 0 || eb == 0) return {s, 31'd0};
        p = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
        e = ea + eb - 127;
        if (p[47]) begin
            m = p[46:24];
            e = e + 1;
        end else begin
            m = p[45:23];
        end
        if (e < 1 || e > 254) return {s, 31'd0};
        return {s, e[7:0], m};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
        int lat;
        int guard;
        logic [31:0] r;
        @(negedge clk);
        opa   = a;
        opb   = b;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat   = 1;
        guard = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            guard++;
            if (guard > 100) break;
            @(posedge clk);
            lat++;
        end
        r = result;
        chk({req, " product"}, r, ref_mul(a, b));
        chk("R8 latency", 32'(lat), (a[30:23] == 0 || b[30:23] == 0) ? 32'd1 : 32'd26);
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
        chk("R9 result held", result, r);
    endtask

    function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
        return {s, e[7:0], f};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        chk("R1 result in reset", result, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        chk("R1 result after reset", result, 32'd0);

        // R4 fixed points: 1*1 no shift, 1.5*1.5 shift
        run_op(32'h3F80_0000, 32'h3F80_0000, "R4 one times one");
        chk("R4 one times one value", result, 32'h3F80_0000);
        run_op(32'h3FC0_0000, 32'h3FC0_0000, "R4 1.5 squared");
        chk("R4 1.5 squared value", result, 32'h4010_0000);
        // R5 truncation: dropped bits nonzero
        run_op(32'h3F80_0001, 32'h3F80_0001, "R5 truncate small");
        chk("R5 truncate small value", result, 32'h3F80_0002);
        run_op(32'h3FFF_FFFF, 32'h3FFF_FFFF, "R5 all ones");
        run_op(32'hBFFF_FFFF, 32'h3F80_0001, "R5 R3 mixed sign");

        // R6 zero operands, fraction bits ignored
        run_op(32'h0000_0000, 32'h4049_0FDB, "R6 pos zero");
        run_op(32'h4049_0FDB, 32'h8000_0000, "R6 R3 neg zero");
        run_op(32'h8000_0000, 32'h8000_0000, "R6 R3 both neg zero");
        run_op(32'h007F_FFFF, 32'hC000_0000, "R6 stray fraction");
        chk("R6 stray fraction value", result, 32'h8000_0000);

        // R7 R4 exponent edges
        for (int ea = 1; ea <= 254; ea += 7) begin
            for (int k = -1; k <= 2; k++) begin
                int eb;
                eb = 127 - ea + k;
                rng = next_rand(rng);
                if (eb >= 1 && eb <= 254)
                    run_op(mk(rng[31], ea, rng[22:0]), mk(rng[30], eb, rng[23:1]), "R7 low edge");
                eb = 381 - ea + k;
                rng = next_rand(rng);
                if (eb >= 1 && eb <= 254)
                    run_op(mk(rng[31], ea, rng[22:0]), mk(rng[30], eb, rng[23:1]), "R7 high edge");
            end
        end

        // R2 R5 single-bit fraction grid
        for (int i = 0; i < 23; i += 2) begin
            for (int j = 0; j < 23; j++) begin
                run_op(mk(1'b0, 127, 23'(1) << i), mk(1'b1, 130, 23'(1) << j), "R2 bit grid");
            end
        end
        for (int i = 0; i < 23; i++) begin
            run_op(mk(1'b0, 100, ~(23'(1) << i)), mk(1'b0, 150, 23'h7FFFFF), "R5 near two");
        end

        // R2 R3 pseudo-random operands
        for (int n = 0; n < 900; n++) begin
            logic [31:0] a, b;
            rng = next_rand(rng);
            a = mk(rng[31], 1 + int'(rng[30:23]) % 254, rng[22:0]);
            rng = next_rand(rng);
            b = mk(rng[31], 1 + int'(rng[30:23]) % 254, rng[22:0]);
            run_op(a, b, "R2 R3 random");
        end

        // R10 start while busy is ignored
        begin
            int lat;
            @(negedge clk);
            opa = 32'h4040_0000;
            opb = 32'hC0A0_0000;
            start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
            lat = 1;
            repeat (5) begin
                @(negedge clk);
                @(posedge clk);
                lat++;
            end
            @(negedge clk);
            opa = 32'h3F80_0000;
            opb = 32'h0000_0000;
            start = 1'b1;
            @(posedge clk);
            lat++;
            #1 start = 1'b0;
            opa = 32'h0;
            opb = 32'h0;
            forever begin
                @(negedge clk);
                if (done || lat > 100) break;
                @(posedge clk);
                lat++;
            end
            chk("R10 result kept", result, 32'hC170_0000);
            chk("R10 latency kept", 32'(lat), 32'd26);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule